// File: doc/BRIEF.md
# Burst SRAM Cycle Controller

This block turns the control pins of a synchronous flow-through SRAM into the internal strobes that run the storage array. On each rising clock edge it checks the three chip selects and two address strobes to decide whether a new access starts. It then loads the address register and produces per-byte write strobes for a small parameterised array. It also decides whether the read data may be driven onto the data bus.

The two address strobes have different rules. The processor strobe is gated by the first chip select and has priority. A cycle it starts ignores the write inputs on its first edge and becomes a write only on the next edge. The controller strobe samples the write inputs on the same edge as the address. A global write forces every byte lane. Once a write is seen, the bus driver is turned off whatever the output enable does. An advance input steps through a four-beat wrapping burst. Read data flows from the registered address to the output in the same cycle, with no output register.

Top module: `burst_sram_ctrl`

## Requirements
- R1: `load_o` is high before a rising edge only when `cs1_ni`=0, `cs2_i`=1 and `cs3_ni`=0 and at least one effective address strobe is low. A strobe seen while the selects are not all active starts nothing.
- R2: `proc_strb_ni` low has no effect while `cs1_ni` is high. It neither starts a cycle nor ends a cycle already open.
- R3: While `proc_strb_ni` is low, `ctrl_strb_ni` is ignored. With both strobes low and the chip selected, the cycle is a processor cycle and no write happens on that edge.
- R4: In a processor-started cycle the write inputs are ignored on the start edge. If they request a write on the next edge, `wdata_i` is written at the loaded address on that edge.
- R5: In a controller-started cycle the write inputs are sampled on the start edge. If they request a write, `wdata_i` is written at `addr_i` on that edge. Otherwise the cycle is a read.
- R6: `gw_ni`=0 makes all byte strobes active, whatever `bwe_ni` and `bsel_ni` are.
- R7: With `gw_ni`=1, byte lane b (bits 8b+7:8b) is written only when `bwe_ni`=0 and `bsel_ni[b]`=0. With `bwe_ni`=1 nothing is written.
- R8: Once a write is requested in an open cycle, `drive_o` is 0 regardless of `oe_ni`. It stays 0 for the rest of that write cycle.
- R9: `drive_o` follows `oe_ni` without a clock: it is 1 only while `oe_ni`=0 during an open read cycle. `rdata_o` is the array word at the registered address in the cycle after the start edge.
- R10: On a non-start edge of an open cycle with `adv_ni`=0, the two low address bits increment and wrap within an aligned group of four. With `adv_ni`=1 the address holds.
- R11: After reset no cycle is open, so `drive_o`=0 and no write strobe is active.
- R12: A strobe edge that starts nothing because of the chip selects closes the open cycle, so `drive_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs1_ni | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2_i | input | 1 | Chip select 2, active high |
| cs3_ni | input | 1 | Chip select 3, active low |
| proc_strb_ni | input | 1 | Processor address strobe, active low |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | NB | Per-byte write select, active low |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | NB*BW | Write data from the bus |
| rdata_o | output | NB*BW | Flow-through read data |
| drive_o | output | 1 | Data bus driver enable |
| load_o | output | 1 | Address register load strobe for this edge |
| wr_strb_o | output | NB | Per-byte write strobes for this edge |

## Verification
Two functions can fall on the same edge. A controller write request and a processor cycle start can arrive together, and a write detection can coincide with an asserted output enable. The first case is provoked by holding both strobes and the global write low with the chip selected. The bench judges it by seeing no write strobe on that edge and then reading back the old word. The second case is judged by `drive_o` falling in the data-phase cycle of a delayed processor write while `oe_ni` stays low.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_PROC  = 2'd1,
    EV_CTRL  = 2'd2,
    EV_DESEL = 2'd3
  } strobe_ev_e;
endpackage

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
  import sram_ctl_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          cs1_ni,
  input  logic          cs2_i,
  input  logic          cs3_ni,
  input  logic          proc_strb_ni,
  input  logic          ctrl_strb_ni,
  input  logic          gw_ni,
  input  logic          bwe_ni,
  input  logic [NB-1:0] bsel_ni,
  output strobe_ev_e    ev_o,
  output logic          wr_req_o,
  output logic [NB-1:0] lane_o
);
  logic cs_all, proc_go, ctrl_go;

  assign cs_all  = !cs1_ni && cs2_i && !cs3_ni;
  // processor strobe gated by select 1; controller strobe masked by processor strobe
  assign proc_go = !proc_strb_ni && !cs1_ni;
  assign ctrl_go = !ctrl_strb_ni && proc_strb_ni;

  always_comb begin
    if (proc_go || ctrl_go) ev_o = !cs_all ? EV_DESEL : (proc_go ? EV_PROC : EV_CTRL);
    else                    ev_o = EV_NONE;
  end

  always_comb begin
    if (!gw_ni)       lane_o = '1;
    else if (!bwe_ni) lane_o = ~bsel_ni;
    else              lane_o = '0;
  end

  assign wr_req_o = |lane_o;
endmodule

// File: rtl/sram_addr_ctrl.sv
module sram_addr_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  strobe_ev_e    ev_i,
  input  logic [AW-1:0] addr_i,
  input  logic          adv_ni,
  input  logic          wr_req_i,
  input  logic          wr_fire_i,
  output logic [AW-1:0] addr_q_o,
  output logic          active_o,
  output logic          wr_cyc_o
);
  localparam int HI = AW - BB;
  logic [BB-1:0] beat_nxt;

  assign beat_nxt = addr_q_o[BB-1:0] + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      active_o <= 1'b0;
      wr_cyc_o <= 1'b0;
    end else begin
      unique case (ev_i)
        EV_PROC: begin
          addr_q_o <= addr_i;
          active_o <= 1'b1;
          wr_cyc_o <= 1'b0;
        end
        EV_CTRL: begin
          addr_q_o <= addr_i;
          active_o <= 1'b1;
          wr_cyc_o <= wr_req_i;
        end
        EV_DESEL: begin
          active_o <= 1'b0;
          wr_cyc_o <= 1'b0;
        end
        default: begin
          if (wr_fire_i) wr_cyc_o <= 1'b1;
          if (active_o && !adv_ni) addr_q_o <= {addr_q_o[AW-1 -: HI], beat_nxt};
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic [NB-1:0]    we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [NB*BW-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [NB*BW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[b]) mem_q[waddr_i] <= wdata_i[b*BW +: BW];
    end
    assign rdata_o[b*BW +: BW] = mem_q[raddr_i];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int AW = 4,
  parameter int NB = 4,
  parameter int BW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs1_ni,
  input  logic             cs2_i,
  input  logic             cs3_ni,
  input  logic             proc_strb_ni,
  input  logic             ctrl_strb_ni,
  input  logic             adv_ni,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [NB-1:0]    bsel_ni,
  input  logic             oe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [NB*BW-1:0] wdata_i,
  output logic [NB*BW-1:0] rdata_o,
  output logic             drive_o,
  output logic             load_o,
  output logic [NB-1:0]    wr_strb_o
);
  localparam int BURST_BITS = 2;

  strobe_ev_e    ev;
  logic          wr_req, wr_fire, active, wr_cyc;
  logic [NB-1:0] lane;
  logic [AW-1:0] addr_q, waddr;

  sram_strobe_decode #(.NB(NB)) i_decode (
    .cs1_ni       (cs1_ni),
    .cs2_i        (cs2_i),
    .cs3_ni       (cs3_ni),
    .proc_strb_ni (proc_strb_ni),
    .ctrl_strb_ni (ctrl_strb_ni),
    .gw_ni        (gw_ni),
    .bwe_ni       (bwe_ni),
    .bsel_ni      (bsel_ni),
    .ev_o         (ev),
    .wr_req_o     (wr_req),
    .lane_o       (lane)
  );

  // controller start writes at once; otherwise only an open cycle writes
  assign wr_fire   = wr_req && ((ev == EV_CTRL) || (active && ev == EV_NONE));
  assign wr_strb_o = wr_fire ? lane : '0;
  assign load_o    = (ev == EV_PROC) || (ev == EV_CTRL);
  assign waddr     = (ev == EV_CTRL) ? addr_i : addr_q;

  sram_addr_ctrl #(.AW(AW), .BB(BURST_BITS)) i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .addr_i    (addr_i),
    .adv_ni    (adv_ni),
    .wr_req_i  (wr_req),
    .wr_fire_i (wr_fire),
    .addr_q_o  (addr_q),
    .active_o  (active),
    .wr_cyc_o  (wr_cyc)
  );

  sram_byte_array #(.AW(AW), .NB(NB), .BW(BW)) i_array (
    .clk_i   (clk_i),
    .we_i    (wr_strb_o),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (addr_q),
    .rdata_o (rdata_o)
  );

  // write detection overrides output enable
  assign drive_o = !oe_ni && active && !wr_cyc && !(wr_req && ev != EV_PROC);
endmodule

// File: rtl/burst_sram_ctrl_chk.sv
module burst_sram_ctrl_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs1_ni,
  input logic          cs2_i,
  input logic          cs3_ni,
  input logic          proc_strb_ni,
  input logic          ctrl_strb_ni,
  input logic          gw_ni,
  input logic          bwe_ni,
  input logic [NB-1:0] bsel_ni,
  input logic          oe_ni,
  input logic          drive_o,
  input logic          load_o,
  input logic [NB-1:0] wr_strb_o
);
  p_start_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!cs1_ni && cs2_i && !cs3_ni && (!proc_strb_ni || !ctrl_strb_ni)));

  p_proc_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs1_ni && !proc_strb_ni) |-> !load_o);

  p_proc_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs1_ni && !proc_strb_ni && !ctrl_strb_ni) |-> (wr_strb_o == '0));

  p_first_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !proc_strb_ni) |-> (wr_strb_o == '0));

  p_global_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gw_ni && wr_strb_o != '0) |-> (&wr_strb_o));

  p_byte_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gw_ni |-> ((wr_strb_o & bsel_ni) == '0) && (!bwe_ni || wr_strb_o == '0));

  p_write_tri_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_strb_o != '0) |-> !drive_o);

  p_write_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_strb_o != '0) && proc_strb_ni && ctrl_strb_ni) |=> !drive_o);

  p_oe_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);
endmodule

bind burst_sram_ctrl burst_sram_ctrl_chk #(.NB(NB)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs1_ni       (cs1_ni),
  .cs2_i        (cs2_i),
  .cs3_ni       (cs3_ni),
  .proc_strb_ni (proc_strb_ni),
  .ctrl_strb_ni (ctrl_strb_ni),
  .gw_ni        (gw_ni),
  .bwe_ni       (bwe_ni),
  .bsel_ni      (bsel_ni),
  .oe_ni        (oe_ni),
  .drive_o      (drive_o),
  .load_o       (load_o),
  .wr_strb_o    (wr_strb_o)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;
  localparam int AW = 4;
  localparam int NB = 4;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs1_n, cs2, cs3_n, proc_n, ctrl_n, adv_n, gw_n, bwe_n, oe_n;
  logic [NB-1:0] bsel_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          drive, load;
  logic [NB-1:0] wr_strb;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [16];

  always #10 clk = ~clk;

  burst_sram_ctrl #(.AW(AW), .NB(NB), .BW(BW)) i_burst_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cs1_ni(cs1_n), .cs2_i(cs2), .cs3_ni(cs3_n),
    .proc_strb_ni(proc_n), .ctrl_strb_ni(ctrl_n), .adv_ni(adv_n), .gw_ni(gw_n),
    .bwe_ni(bwe_n), .bsel_ni(bsel_n), .oe_ni(oe_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .drive_o(drive), .load_o(load), .wr_strb_o(wr_strb)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; proc_n = 1'b1; ctrl_n = 1'b1;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1; oe_n = 1'b0;
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic ctrl_write(input logic [3:0] a, input logic [31:0] d, input logic g,
                            input logic be, input logic [3:0] bs, input logic [3:0] m, input string req);
    @(negedge clk); idle();
    ctrl_n = 1'b0; addr = a; wdata = d; gw_n = g; bwe_n = be; bsel_n = bs;
    #2;
    chk(load == 1'b1, "R5", 32'(load), 32'd1);
    chk(wr_strb == m, req, 32'(wr_strb), 32'(m));
    @(posedge clk);
    model[a] = merge(model[a], d, m);
    #1;
  endtask

  task automatic read_start(input logic [3:0] a);
    @(negedge clk); idle();
    ctrl_n = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk); idle();
    #2;
  endtask

  task automatic t_reset();
    idle(); addr = '0; wdata = '0;
    #25;
    chk(drive == 1'b0, "R11", 32'(drive), 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    #2;
    chk(drive == 1'b0 && wr_strb == '0, "R11", 32'({drive, wr_strb}), 32'd0);
    gw_n = 1'b0; #2;
    chk(wr_strb == '0, "R11", 32'(wr_strb), 32'd0);
    idle();
  endtask

  task automatic t_ctrl_rw();
    ctrl_write(4'd3, 32'hDEADBEEF, 1'b0, 1'b1, 4'hF, 4'hF, "R6");
    read_start(4'd3);
    chk(drive == 1'b1, "R9", 32'(drive), 32'd1);
    chk(rdata == model[3], "R5", rdata, model[3]);
    oe_n = 1'b1; #2;
    chk(drive == 1'b0, "R9", 32'(drive), 32'd0);
    oe_n = 1'b0; #2;
    chk(drive == 1'b1, "R9", 32'(drive), 32'd1);
    ctrl_write(4'd4, 32'h01020304, 1'b1, 1'b0, 4'h0, 4'hF, "R7");
    read_start(4'd4);
    chk(rdata == 32'h01020304, "R5", rdata, 32'h01020304);
  endtask

  task automatic t_byte_merge();
    ctrl_write(4'd5, 32'h11223344, 1'b0, 1'b1, 4'hF, 4'hF, "R6");
    ctrl_write(4'd5, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010, 4'b0101, "R7");
    read_start(4'd5);
    chk(rdata == 32'h11BB33DD, "R7", rdata, 32'h11BB33DD);
    ctrl_write(4'd5, 32'hFFFFFFFF, 1'b1, 1'b1, 4'h0, 4'h0, "R7");
    read_start(4'd5);
    chk(rdata == 32'h11BB33DD, "R7", rdata, 32'h11BB33DD);
    ctrl_write(4'd6, 32'h55AA55AA, 1'b0, 1'b1, 4'hF, 4'hF, "R6");
    ctrl_write(4'd6, 32'h12345678, 1'b0, 1'b0, 4'b0111, 4'hF, "R6");
    read_start(4'd6);
    chk(rdata == 32'h12345678, "R6", rdata, 32'h12345678);
  endtask

  task automatic t_proc_write();
    @(negedge clk); idle();
    proc_n = 1'b0; addr = 4'd7; gw_n = 1'b0; wdata = 32'h11111111;
    #2;
    chk(load == 1'b1, "R4", 32'(load), 32'd1);
    chk(wr_strb == '0, "R4", 32'(wr_strb), 32'd0);
    @(posedge clk);
    @(negedge clk); idle();
    gw_n = 1'b0; wdata = 32'hC0FFEE00;
    #2;
    chk(wr_strb == 4'hF, "R4", 32'(wr_strb), 32'hF);
    chk(drive == 1'b0, "R8", 32'(drive), 32'd0);
    @(posedge clk);
    model[7] = 32'hC0FFEE00;
    @(negedge clk); idle();
    #2;
    chk(drive == 1'b0, "R8", 32'(drive), 32'd0);
    @(negedge clk); idle();
    proc_n = 1'b0; addr = 4'd7;
    @(posedge clk);
    @(negedge clk); idle();
    #2;
    chk(drive == 1'b1 && rdata == model[7], "R4", rdata, model[7]);
  endtask

  task automatic t_priority();
    ctrl_write(4'd2, 32'hA5A5A5A5, 1'b0, 1'b1, 4'hF, 4'hF, "R6");
    @(negedge clk); idle();
    proc_n = 1'b0; ctrl_n = 1'b0; gw_n = 1'b0; addr = 4'd2; wdata = 32'h5A5A5A5A;
    #2;
    chk(wr_strb == '0, "R3", 32'(wr_strb), 32'd0);
    @(posedge clk);
    @(negedge clk); idle();
    #2;
    chk(drive == 1'b1 && rdata == model[2], "R3", rdata, model[2]);
    @(negedge clk); idle();
    cs1_n = 1'b1; proc_n = 1'b0; ctrl_n = 1'b0;
    #2;
    chk(load == 1'b0, "R2", 32'(load), 32'd0);
    @(posedge clk);
    @(negedge clk); idle();
    #2;
    chk(drive == 1'b1 && rdata == model[2], "R2", 32'(drive), 32'd1);
    @(negedge clk); idle();
    cs3_n = 1'b1; ctrl_n = 1'b0;
    #2;
    chk(load == 1'b0, "R1", 32'(load), 32'd0);
    cs3_n = 1'b0; cs2 = 1'b0;
    #2;
    chk(load == 1'b0, "R1", 32'(load), 32'd0);
    @(posedge clk);
    @(negedge clk); idle();
    #2;
    chk(drive == 1'b0, "R12", 32'(drive), 32'd0);
  endtask

  task automatic t_burst();
    for (int i = 0; i < 4; i++)
      ctrl_write(4'(8 + i), 32'h80 + 32'(i), 1'b0, 1'b1, 4'hF, 4'hF, "R6");
    read_start(4'd10);
    for (int i = 0; i < 5; i++) begin
      chk(rdata == model[8 + ((2 + i) % 4)], "R10", rdata, model[8 + ((2 + i) % 4)]);
      adv_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      #2;
    end
    adv_n = 1'b1;
    chk(rdata == model[11], "R10", rdata, model[11]);
    @(posedge clk);
    @(negedge clk);
    #2;
    chk(rdata == model[11], "R10", rdata, model[11]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    t_reset();
    t_ctrl_rw();
    t_byte_merge();
    t_proc_write();
    t_priority();
    t_burst();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule